// File: doc/BRIEF.md
# Dual-Section Ripple Binary Counter

This block is a binary counter built from falling-edge toggle stages and split into two sections that share nothing but the clear logic. The low section is a single toggle stage that divides its own clock by two. The high section is a chain of toggle stages, three by default. The high section's first stage runs on a second clock, and each later stage runs on the falling output of the stage before it. The outputs therefore settle one stage after another rather than all together.

For a full counter, the integrator routes the low-section output back into the high-section clock outside the block and feeds count pulses to the low-section clock. The outputs then form a plain binary count with bit 0 as the least significant bit. To use only the high section, pulses go to its clock alone and bits 1 and up divide that clock by 2, 4 and 8. Two active-high clear inputs are combined by AND. When both are high, every stage clears at once, whatever the clocks are doing.

Top module: `dual_ripple_counter`

## Requirements
- R1: Each falling edge of `tick_a_i` inverts `count_o[0]` while the block is not cleared.
- R2: The two sections are independent: edges on `tick_b_i` never change `count_o[0]`, and edges on `tick_a_i` never change `count_o[3:1]` unless the two are tied together outside the block.
- R3: The high section holds a binary value on `count_o[3:1]`, with bit 1 as the least significant bit. Each falling edge of `tick_b_i` adds one, and the value wraps from 7 to 0.
- R4: The stages form a ripple chain: `count_o[2]` changes only when `count_o[1]` falls, and `count_o[3]` changes only when `count_o[2]` falls.
- R5: While `clr_a_i` and `clr_b_i` are both high, all outputs go to 0 at once, without waiting for a clock edge.
- R6: When only one of the two clear inputs is high, nothing is cleared and counting goes on normally.
- R7: While the clear is active, clock edges have no effect. After release, the first falling edge counts up from 0.
- R8: With `count_o[0]` tied to `tick_b_i` and pulses on `tick_a_i`, `count_o` steps through 0 to 15 and wraps to 0. Bits 0, 1, 2 and 3 then run at 1/2, 1/4, 1/8 and 1/16 of the pulse rate.
- R9: With pulses on `tick_b_i` only, bits 1, 2 and 3 run at 1/2, 1/4 and 1/8 of the pulse rate, and bit 0 stays constant.
- R10: Rising edges on either clock have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tick_a_i | input | 1 | Falling-edge clock of the low section (one toggle stage) |
| tick_b_i | input | 1 | Falling-edge clock of the first stage of the high section |
| clr_a_i | input | 1 | Clear request, active high; acts only together with `clr_b_i` |
| clr_b_i | input | 1 | Clear request, active high; acts only together with `clr_a_i` |
| count_o | output | UPPER_BITS+1 (4) | Stage outputs; bit 0 comes from the low section, bits 1 and up from the high section |

## Verification
The assertions check on every stage edge that a stage really inverts between one falling edge of its own clock and the next rising edge. They also check that the high section advances by exactly one per step, and that the outputs read zero at any clock edge taken while the clear is active. What only the bench scenarios can show is the behaviour at the block's edge. This covers the AND of the two clear inputs, the clear taking effect with both clocks idle, the indifference to rising edges, and the wrap points. It also covers the frequency ratios in the externally linked mode and in the high-section-only mode.

// File: rtl/drc_pkg.sv
package drc_pkg;
  // Default number of toggle stages in the high section.
  localparam int UPPER_BITS_DEF = 3;
endpackage

// File: rtl/rc_tflop.sv
module rc_tflop (
  input  logic tick_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_nxt;

  always_comb begin
    q_nxt = ~q_o;
  end

  always_ff @(negedge tick_i or posedge clr_i) begin
    if (clr_i) q_o <= 1'b0;
    else       q_o <= q_nxt;
  end

  // Checker state: the value seen at the last falling edge, valid only once
  // a falling edge has happened since the last clear.
  logic q_seen;
  logic armed;
  always_ff @(negedge tick_i or posedge clr_i) begin
    if (clr_i) begin
      armed  <= 1'b0;
      q_seen <= 1'b0;
    end else begin
      armed  <= 1'b1;
      q_seen <= q_o;
    end
  end

  // R1 / R4: a stage inverts once on every falling edge of its own clock.
  assert_stage_toggle_R1: assert property (@(posedge tick_i) disable iff (clr_i)
    armed |-> (q_o != q_seen));

  // R5 / R7: any clock edge taken while cleared finds the stage at zero.
  assert_clear_holds_R5: assert property (@(negedge tick_i)
    clr_i |-> (q_o == 1'b0));
endmodule

// File: rtl/rc_chain.sv
module rc_chain #(
  parameter int WIDTH = drc_pkg::UPPER_BITS_DEF
) (
  input  logic             tick_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_tick;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign stage_tick[i] = tick_i;
    end else begin : g_link
      assign stage_tick[i] = q_o[i-1];
    end
    rc_tflop u_tff (
      .tick_i(stage_tick[i]),
      .clr_i (clr_i),
      .q_o   (q_o[i])
    );
  end

  // Checker state for the step assertion.
  logic [WIDTH-1:0] val_seen;
  logic             armed;
  always_ff @(negedge tick_i or posedge clr_i) begin
    if (clr_i) begin
      armed    <= 1'b0;
      val_seen <= '0;
    end else begin
      armed    <= 1'b1;
      val_seen <= q_o;
    end
  end

  // R3 / R4: once the ripple has settled, the section has advanced by one.
  assert_chain_step_R3: assert property (@(posedge tick_i) disable iff (clr_i)
    armed |-> (q_o == WIDTH'(val_seen + 1'b1)));
endmodule

// File: rtl/dual_ripple_counter.sv
module dual_ripple_counter #(
  parameter int UPPER_BITS = drc_pkg::UPPER_BITS_DEF
) (
  input  logic              tick_a_i,
  input  logic              tick_b_i,
  input  logic              clr_a_i,
  input  logic              clr_b_i,
  output logic [UPPER_BITS:0] count_o
);
  logic clr_all;
  assign clr_all = clr_a_i & clr_b_i;

  rc_tflop u_low (
    .tick_i(tick_a_i),
    .clr_i (clr_all),
    .q_o   (count_o[0])
  );

  rc_chain #(.WIDTH(UPPER_BITS)) u_high (
    .tick_i(tick_b_i),
    .clr_i (clr_all),
    .q_o   (count_o[UPPER_BITS:1])
  );

  // R5 / R7: a high-section clock edge taken during a clear sees all zeros.
  assert_full_clear_R5: assert property (@(negedge tick_b_i)
    clr_all |-> (count_o == '0));
endmodule

// File: tb/dual_ripple_counter_test.sv
module dual_ripple_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  // Vector format: [5] pulse on tick_a, [4] pulse on tick_b, [3:0] expected count.
  localparam logic [5:0] VEC [0:11] = '{
    6'b10_0001, 6'b01_0011, 6'b01_0101, 6'b10_0100,
    6'b01_0110, 6'b01_1000, 6'b10_1001, 6'b01_1011,
    6'b01_1101, 6'b01_1111, 6'b01_0001, 6'b10_0000
  };

  logic       tick_a = 1'b1;
  logic       tick_b_drv = 1'b1;
  logic       link = 1'b0;
  logic       clr_a = 1'b1;
  logic       clr_b = 1'b1;
  logic       tick_b;
  logic [3:0] count;
  int         total = 0;
  int         bad = 0;

  assign tick_b = link ? count[0] : tick_b_drv;

  dual_ripple_counter uut (
    .tick_a_i(tick_a),
    .tick_b_i(tick_b),
    .clr_a_i (clr_a),
    .clr_b_i (clr_b),
    .count_o (count)
  );

  task automatic check(input logic [3:0] exp, input string tag);
    total++;
    if (count !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, count, exp);
    end
  endtask

  task automatic check_int(input int got, input int exp, input string tag);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic pulse_a();
    tick_a = 1'b0; #(HALF);
    tick_a = 1'b1; #(HALF);
  endtask

  task automatic pulse_b();
    tick_b_drv = 1'b0; #(HALF);
    tick_b_drv = 1'b1; #(HALF);
  endtask

  initial begin
    int rises [4];
    logic [3:0] prev;
    #(CLK_PERIOD * 2);
    check(4'b0000, "R5 reset state");
    clr_a = 1'b0; clr_b = 1'b0;
    #(CLK_PERIOD);

    // Table walk, sections driven separately (R1 R2 R3 R4).
    for (int i = 0; i < 12; i++) begin
      if (VEC[i][5]) pulse_a();
      if (VEC[i][4]) pulse_b();
      check(VEC[i][3:0], "R1 R2 R3 R4 table step");
    end

    // R10: only falling edges count.
    tick_a = 1'b0; #(HALF); check(4'b0001, "R1 falling edge on a");
    tick_a = 1'b1; #(HALF); check(4'b0001, "R10 rising edge on a");
    tick_b_drv = 1'b0; #(HALF); check(4'b0011, "R3 falling edge on b");
    tick_b_drv = 1'b1; #(HALF); check(4'b0011, "R10 rising edge on b");

    // R5: clear with both clocks idle.
    clr_a = 1'b1; clr_b = 1'b1; #1;
    check(4'b0000, "R5 asynchronous clear");
    // R7: edges during clear are ignored.
    pulse_a(); pulse_b();
    check(4'b0000, "R7 edges during clear");
    clr_a = 1'b0; clr_b = 1'b0; #(HALF);
    pulse_a(); check(4'b0001, "R7 first edge after release");
    pulse_b(); check(4'b0011, "R7 high section after release");

    // R6: a single clear input does nothing.
    clr_a = 1'b1; #(HALF);
    check(4'b0011, "R6 only clr_a high holds value");
    pulse_a(); check(4'b0010, "R6 counting with clr_a high");
    clr_a = 1'b0; clr_b = 1'b1; #(HALF);
    pulse_b(); check(4'b0100, "R6 counting with clr_b high");
    clr_b = 1'b0; #(HALF);

    // R8: externally linked 4-bit mode.
    clr_a = 1'b1; clr_b = 1'b1; #(HALF);
    link = 1'b1; #(HALF);
    clr_a = 1'b0; clr_b = 1'b0; #(HALF);
    check(4'b0000, "R8 linked start");
    for (int b = 0; b < 4; b++) rises[b] = 0;
    for (int i = 0; i < 40; i++) begin
      prev = count;
      pulse_a();
      check(4'((i + 1) % 16), "R8 binary sequence");
      if (i < 32)
        for (int b = 0; b < 4; b++) if (!prev[b] && count[b]) rises[b]++;
    end
    check_int(rises[0], 16, "R8 bit0 divide by 2");
    check_int(rises[1], 8,  "R8 bit1 divide by 4");
    check_int(rises[2], 4,  "R8 bit2 divide by 8");
    check_int(rises[3], 2,  "R8 bit3 divide by 16");

    // R9: high section alone.
    clr_a = 1'b1; clr_b = 1'b1; #(HALF);
    link = 1'b0; #(HALF);
    clr_a = 1'b0; clr_b = 1'b0; #(HALF);
    for (int b = 0; b < 4; b++) rises[b] = 0;
    for (int i = 0; i < 16; i++) begin
      prev = count;
      pulse_b();
      check({3'((i + 1) % 8), 1'b0}, "R9 R3 high-only sequence");
      for (int b = 0; b < 4; b++) if (!prev[b] && count[b]) rises[b]++;
    end
    check_int(rises[0], 0, "R9 R2 bit0 untouched");
    check_int(rises[1], 8, "R9 bit1 divide by 2");
    check_int(rises[2], 4, "R9 bit2 divide by 4");
    check_int(rises[3], 2, "R9 bit3 divide by 8");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule